// File: doc/BRIEF.md
# Bank-switched register window decoder

This unit gives a host access to a larger set of internal registers through a 16-byte I/O window. The registers are split into banks. The word at the top of the window holds a bank-select register, and that register is visible whatever bank is active. Host accesses use a dword index and four byte-enable lanes. A byte, a word or a full doubleword can therefore reach any register. Each enabled lane is steered to the matching byte of the active bank.

Banks 0 to 3 are internal byte storage that loads computed defaults at reset. Banks 4 to 6 are reserved. Bank 7 is forwarded unchanged to a simple external-register port. Read data is combinational. Writes take effect at the clock edge that samples the strobe.

Top module: `bank_window`

## Requirements
- R1: Byte lane k of dword index `addr_i` addresses window offset 4*addr_i+k. A register's low byte, bits 7:0, sits at its even offset and its high byte, bits 15:8, at offset plus one.
- R2: Offset 0xE holds the bank number in bits 2:0 in every bank, and bits 7:3 read as zero. Offset 0xF always reads 0xA5, and writes to it are ignored.
- R3: A write with lane 2 enabled at dword 3 loads the bank number from `wdata_i[18:16]`. The new bank applies from the next access onward. Other lanes of that same access still use the old bank.
- R4: A write changes only the bytes whose lanes are enabled. The other byte of the same 16-bit location keeps its value.
- R5: `rdata_o` returns all four bytes of the addressed dword of the active bank, combinationally in the same cycle.
- R6: After reset the bank is 0, and byte offset o of internal bank b reads ((b+1)*16+o) mod 256 for every implemented offset.
- R7: Offsets 0xC and 0xD of bank 0 and offsets 0x0 to 0xD of banks 4 to 6 read zero and ignore writes.
- R8: While bank 7 is active, a strobe with at least one enabled lane outside offsets 0xE/0xF raises `ext_stb_o`. The port passes `ext_we_o`=`wr_i`, `ext_addr_o`=`addr_i`, `ext_wdata_o`=`wdata_i` and `ext_be_o`=`be_i` with the bank-select lanes cleared. Those lanes of `rdata_o` come from `ext_rdata_i`.
- R9: `ext_stb_o` stays low whenever the active bank is not 7.
- R10: In bank 7, lanes that hit offsets 0xE/0xF are never enabled on the external port, and their read data comes from the bank-select register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 2 | Dword index within the window |
| be_i | input | 4 | Byte-lane enables |
| wdata_i | input | 32 | Write data |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| rdata_o | output | 32 | Combinational read data |
| ext_stb_o | output | 1 | External-register strobe |
| ext_we_o | output | 1 | External write flag |
| ext_addr_o | output | 2 | External dword index |
| ext_be_o | output | 4 | External byte enables |
| ext_wdata_o | output | 32 | External write data |
| ext_rdata_i | input | 32 | External read data |

## Verification
Two functions can fall in the same cycle: a data write to the lower half of dword 3 and a bank change in its upper half. The bench provokes this with full-doubleword writes at index 3. It does so from an internal bank, from bank 7 and under random stimulus. A behavioural model decides that the lower bytes land in the bank that was active before the edge, and that the external port sees only lanes 0 and 1. The model then compares reads from both the old and the new bank.

// File: rtl/bank_win_pkg.sv
package bank_win_pkg;
  localparam int WIN_BYTES = 16;
  localparam int LANES     = 4;
  localparam int DW        = 8 * LANES;
  localparam int AW        = $clog2(WIN_BYTES / LANES);
  localparam int BANK_W    = 3;
  localparam int INT_BANKS = 4;
  localparam int IB_W      = $clog2(INT_BANKS);
  localparam int EXT_BANK  = 7;
  localparam int BSEL_OFF  = 14;
  localparam int BSEL_DW   = BSEL_OFF / LANES;
  localparam int BSEL_LANE = BSEL_OFF % LANES;
  localparam logic [7:0] BSEL_HI = 8'hA5;

  function automatic logic [7:0] reset_byte(int bank, int off);
    return 8'((bank + 1) * 16 + off);
  endfunction

  function automatic bit is_impl(int bank, int off);
    return (off < BSEL_OFF) && !(bank == 0 && off >= 12);
  endfunction

  // lanes of a dword that belong to the bank-select word
  function automatic logic [LANES-1:0] bsel_lanes(logic [AW-1:0] addr);
    return (int'(addr) == BSEL_DW) ? LANES'(3 << BSEL_LANE) : '0;
  endfunction
endpackage

// File: rtl/bank_reg_file.sv
module bank_reg_file
  import bank_win_pkg::*;
#(
  parameter int BANK_ID = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o
);
  logic [8*WIN_BYTES-1:0] bytes_w;

  for (genvar off = 0; off < WIN_BYTES; off++) begin : g_byte
    if (is_impl(BANK_ID, off)) begin : g_reg
      logic [7:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= reset_byte(BANK_ID, off);
        else if (we_i && addr_i == AW'(off / LANES) && be_i[off % LANES])
          q <= wdata_i[8*(off % LANES) +: 8];
      end
      assign bytes_w[8*off +: 8] = q;
    end else begin : g_rsvd
      assign bytes_w[8*off +: 8] = 8'h00;
    end
  end

  assign rdata_o = bytes_w[DW*addr_i +: DW];

  p_idle_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(bytes_w));
  p_lane_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == '0 && !be_i[1]) |=> $stable(bytes_w[15:8]));
endmodule

// File: rtl/bank_sel_reg.sv
module bank_sel_reg
  import bank_win_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [BANK_W-1:0] bank_o,
  output logic [DW-1:0]     rdata_o
);
  logic hit;
  assign hit = we_i && int'(addr_i) == BSEL_DW && be_i[BSEL_LANE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  bank_o <= '0;
    else if (hit) bank_o <= wdata_i[8*BSEL_LANE +: BANK_W];
  end

  assign rdata_o = (int'(addr_i) == BSEL_DW)
                 ? (DW'({BSEL_HI, 8'(bank_o)}) << (8*BSEL_LANE)) : '0;

  p_bank_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> bank_o == $past(wdata_i[8*BSEL_LANE +: BANK_W]));
  p_bank_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> $stable(bank_o));
endmodule

// File: rtl/bank_ext_port.sv
module bank_ext_port
  import bank_win_pkg::*;
(
  input  logic [BANK_W-1:0] bank_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [DW-1:0]     ext_rdata_i,
  output logic              ext_stb_o,
  output logic              ext_we_o,
  output logic [AW-1:0]     ext_addr_o,
  output logic [LANES-1:0]  ext_be_o,
  output logic [DW-1:0]     ext_wdata_o,
  output logic [DW-1:0]     rdata_o
);
  logic             sel;
  logic [LANES-1:0] keep;

  assign sel  = int'(bank_i) == EXT_BANK;
  assign keep = ~bsel_lanes(addr_i);

  assign ext_be_o    = be_i & keep;
  assign ext_stb_o   = sel && (rd_i || wr_i) && |ext_be_o;
  assign ext_we_o    = wr_i;
  assign ext_addr_o  = addr_i;
  assign ext_wdata_o = wdata_i;

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < LANES; k++)
      if (sel && keep[k]) rdata_o[8*k +: 8] = ext_rdata_i[8*k +: 8];
  end

  always_comb begin
    if (int'(addr_i) == BSEL_DW)
      a_bsel_masked_r10: assert (ext_be_o[BSEL_LANE] == 1'b0 && ext_be_o[BSEL_LANE+1] == 1'b0);
  end
endmodule

// File: rtl/bank_window.sv
module bank_window
  import bank_win_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic [DW-1:0]     rdata_o,
  output logic              ext_stb_o,
  output logic              ext_we_o,
  output logic [AW-1:0]     ext_addr_o,
  output logic [LANES-1:0]  ext_be_o,
  output logic [DW-1:0]     ext_wdata_o,
  input  logic [DW-1:0]     ext_rdata_i
);
  logic [BANK_W-1:0]             bank_q;
  logic [DW-1:0]                 bsel_rd, ext_rd;
  logic [INT_BANKS-1:0][DW-1:0]  rf_rd;
  logic                          int_sel;

  bank_sel_reg i_bsel (
    .clk_i, .rst_ni, .we_i(wr_i), .addr_i, .be_i, .wdata_i,
    .bank_o(bank_q), .rdata_o(bsel_rd)
  );

  for (genvar b = 0; b < INT_BANKS; b++) begin : g_bank
    bank_reg_file #(.BANK_ID(b)) i_rf (
      .clk_i, .rst_ni,
      .we_i   (wr_i && int'(bank_q) == b),
      .addr_i, .be_i, .wdata_i,
      .rdata_o(rf_rd[b])
    );
  end

  bank_ext_port i_ext (
    .bank_i(bank_q), .rd_i, .wr_i, .addr_i, .be_i, .wdata_i, .ext_rdata_i,
    .ext_stb_o, .ext_we_o, .ext_addr_o, .ext_be_o, .ext_wdata_o,
    .rdata_o(ext_rd)
  );

  assign int_sel = int'(bank_q) < INT_BANKS;
  assign rdata_o = bsel_rd | ext_rd | (int_sel ? rf_rd[bank_q[IB_W-1:0]] : '0);

  p_ext_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(bank_q) != EXT_BANK |-> !ext_stb_o);
  p_hi_const_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(addr_i) == BSEL_DW |-> rdata_o[8*(BSEL_LANE+1) +: 8] == BSEL_HI);
endmodule

// File: tb/test_bank_window.sv
module test_bank_window;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [31:0] rdata;
  logic        ext_stb, ext_we;
  logic [1:0]  ext_addr;
  logic [3:0]  ext_be;
  logic [31:0] ext_wdata;
  logic [31:0] ext_rdata = 32'h9C8B_7A69;

  int checks = 0, fails = 0;
  logic [7:0] mem [4][16];
  int bnk;

  always #5 clk = ~clk;

  bank_window i_bank_window (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .be_i(be), .wdata_i(wdata),
    .rd_i(rd), .wr_i(wr), .rdata_o(rdata), .ext_stb_o(ext_stb), .ext_we_o(ext_we),
    .ext_addr_o(ext_addr), .ext_be_o(ext_be), .ext_wdata_o(ext_wdata),
    .ext_rdata_i(ext_rdata)
  );

  function automatic bit impl(int b, int o);
    return b < 4 && o < 14 && !(b == 0 && o >= 12);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(int a);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) begin
      int o;
      o = 4*a + k;
      if (o == 14)          r[8*k +: 8] = 8'(bnk);
      else if (o == 15)     r[8*k +: 8] = 8'hA5;
      else if (impl(bnk, o)) r[8*k +: 8] = mem[bnk][o];
      else if (bnk == 7)    r[8*k +: 8] = ext_rdata[8*k +: 8];
      else                  r[8*k +: 8] = 8'h00;
    end
    return r;
  endfunction

  task automatic acc(bit w, int a, logic [3:0] b, logic [31:0] d, string tag);
    logic [3:0] xbe;
    bit xstb;
    int nb;
    @(negedge clk);
    addr = 2'(a); be = b; wdata = d; wr = w; rd = !w;
    #1;
    xbe  = (a == 3) ? (b & 4'b0011) : b;
    xstb = (bnk == 7) && (xbe != 0);
    if (!w) chk({tag, " R5 read"}, rdata, model_read(a));
    chk({tag, " R8/R9 stb"}, 32'(ext_stb), 32'(xstb));
    if (xstb) begin
      chk({tag, " R8 be R10"}, 32'(ext_be), 32'(xbe));
      chk({tag, " R8 we/addr"}, {30'(ext_addr), 1'b0, ext_we}, {30'(a), 1'b0, w});
      chk({tag, " R8 wdata"}, ext_wdata, d);
    end
    @(posedge clk);
    if (w) begin
      nb = bnk;
      for (int k = 0; k < 4; k++) begin
        int o;
        o = 4*a + k;
        if (b[k]) begin
          if (o == 14) nb = int'(d[8*k +: 3]);
          else if (impl(bnk, o)) mem[bnk][o] = d[8*k +: 8];
        end
      end
      bnk = nb;
    end
    #1;
    rd = 1'b0; wr = 1'b0;
  endtask

  task automatic read_all(string tag);
    for (int a = 0; a < 4; a++) acc(1'b0, a, 4'hF, 32'h0, tag);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    bnk = 0;
    for (int b = 0; b < 4; b++)
      for (int o = 0; o < 16; o++) mem[b][o] = impl(b, o) ? 8'((b+1)*16 + o) : 8'h00;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset stb", 32'(ext_stb), 32'd0);
    rst_n = 1'b1;
    read_all("R6 reset bank0 R7 R2");
    // R2: upper bank-select byte ignores writes
    acc(1'b1, 3, 4'b1000, 32'hFF00_0000, "R2 hi write");
    acc(1'b0, 3, 4'b1100, 32'h0, "R2 hi read");
    // R7: bank 0 reserved offsets
    acc(1'b1, 3, 4'b0011, 32'h0000_BEEF, "R7 bank0 rsvd");
    acc(1'b0, 3, 4'hF, 32'h0, "R7 bank0 rsvd read");
    // R3: switch to bank 1
    acc(1'b1, 3, 4'b0100, 32'h00F9_0000, "R3 sel1");
    read_all("R6 bank1");
    // R4 / R1: byte and word writes
    acc(1'b1, 1, 4'b0010, 32'h00AA_5500, "R4 byte");
    acc(1'b0, 1, 4'hF, 32'h0, "R4 byte read R1");
    acc(1'b1, 0, 4'b1100, 32'h1234_5678, "R4 word");
    acc(1'b1, 2, 4'hF, 32'hCAFE_F00D, "R4 dword");
    read_all("R4 bank1 after");
    // R3: combined dword write: lower lanes to bank1, then bank 2
    acc(1'b1, 3, 4'hF, 32'hFF02_7766, "R3 combined");
    read_all("R3 bank2");
    acc(1'b1, 3, 4'b0100, 32'h0001_0000, "R3 back1");
    acc(1'b0, 3, 4'hF, 32'h0, "R3 bank1 kept");
    // R7: reserved banks 4..6
    for (int b = 4; b < 7; b++) begin
      acc(1'b1, 3, 4'b0100, 32'(b) << 16, "R3 sel rsvd");
      for (int a = 0; a < 4; a++) acc(1'b1, a, 4'b0011, 32'hDEAD_BEEF, "R7 rsvd write");
      read_all("R7 rsvd read");
    end
    // R8 / R10: external bank
    acc(1'b1, 3, 4'b0100, 32'h0007_0000, "R3 sel7");
    read_all("R8 ext read");
    ext_rdata = 32'h0102_0304;
    acc(1'b1, 1, 4'b0110, 32'h4455_6677, "R8 ext write");
    acc(1'b0, 2, 4'b0001, 32'h0, "R8 ext byte read");
    acc(1'b0, 3, 4'b1100, 32'h0, "R10 bsel only");
    acc(1'b1, 3, 4'hF, 32'h0003_1122, "R10 combined ext");
    read_all("R6 bank3");
    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      ext_rdata = $urandom;
      acc(r[0], int'(r[2:1]), r[7:4], $urandom, "R1 random");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule